// File: doc/BRIEF.md
# Synthesizer Divider Core with Power-Down Control

This block is the digital heart of a phase-locked frequency synthesizer. It holds a reference divider and a feedback divider. Each divider counts single-cycle tick pulses: `ref_tick` comes from the reference oscillator and `fb_tick` comes from the prescaled oscillator. The two divided pulse trains feed a phase-frequency detector, which drives `pump_up` and `pump_dn` requests toward an external charge pump. All inputs are sampled on the rising edge of the system clock `clk`.

Software programs the dividers through a three-wire serial port with clock, data and load strobe. The port is sampled on `clk` and edge-detected. Each word is `WORD_W` bits, where `WORD_W = 1 + max(RDIV_W, NDIV_W + 3)`. A word whose bit 0 is set is a feedback word, and it also carries the detector polarity and two power-down controls. With the request bit and the immediate bit both set, the block powers down at once. With only the request bit set, it waits until no pump request is active. While powered down, both dividers sit at zero and the pump outputs are low. On power-up both dividers restart from zero together, so the first divided pulses arrive in a known phase relationship. The serial port keeps working throughout.

Top module: `synth_pd_core`

## Requirements
- R1: A rising edge of `ser_clk` shifts `ser_data` into the shift register, most significant bit first. Only the last `WORD_W` bits shifted in are kept, so earlier extra bits are discarded.
- R2: A rising edge of `ser_le` copies the shift register into a latch. If bit 0 is 0, bits [RDIV_W:1] set the reference divide value. If bit 0 is 1, the word sets: power-down request in bit 1, immediate mode in bit 2, polarity in bit 3, and the feedback divide value in bits [NDIV_W+3:4]. The latch that is not addressed keeps its contents.
- R3: When powered up, `fr_out` gives a one-cycle pulse on every R-th `ref_tick` and `fp_out` gives one on every N-th `fb_tick`. A divide value of 0 or 1 produces a pulse on every tick.
- R4: When the polarity bit is 1, an `fr_out` pulse sets the up request and an `fp_out` pulse sets the down request. When the polarity bit is 0, the roles are swapped.
- R5: When up and down are both high, both are cleared on the next cycle. A locked loop therefore still sees one-cycle pulses on both outputs.
- R6: A feedback word with bits 1 and 2 both set raises `pwr_down` two clock edges after the edge that samples the `ser_le` rise. This happens even while a pump request is active.
- R7: A feedback word with bit 1 set and bit 2 clear raises `pwr_down` only on an edge where neither the up nor the down request was active.
- R8: Latching a feedback word with bit 1 clear cancels a pending synchronous power-down. It also ends any power-down already in effect.
- R9: While `pwr_down` is high, `pump_up` and `pump_dn` are low. From the second powered-down cycle onward, `fr_out` and `fp_out` are low and both divider counts are zero.
- R10: After power-up, both dividers start from zero. The first `fr_out` follows the R-th `ref_tick` and the first `fp_out` follows the N-th `fb_tick`.
- R11: The serial port shifts and latches words while `pwr_down` is high. A reference value written during power-down takes effect on power-up.
- R12: After reset, `pwr_down`, `pump_up`, `pump_dn`, `fr_out` and `fp_out` are low. Both divide values are 1 and the polarity bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled on `clk` |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; its rising edge latches the word |
| ref_tick | input | 1 | One-cycle reference event |
| fb_tick | input | 1 | One-cycle feedback event |
| fr_out | output | 1 | Divided reference pulse |
| fp_out | output | 1 | Divided feedback pulse |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pwr_down | output | 1 | Powered-down status |

## Verification
The assertions assume that `ser_clk` and `ser_le` are slow levels held for at least one `clk` cycle, so each edge is seen exactly once. They also assume `ref_tick` and `fb_tick` are synchronous to `clk`. The bench changes every input on the falling edge of `clk` and holds each serial level for two cycles. Two scenarios are set up on purpose. In one, the feedback ticks are withheld, so the up request stays high and the synchronous entry must wait. In the other, a cancelling word arrives while that wait is still pending.

// File: rtl/synth_pd_core.sv
module synth_pd_core #(
  parameter int RDIV_W = 8,
  parameter int NDIV_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_le,
  input  logic ref_tick,
  input  logic fb_tick,
  output logic fr_out,
  output logic fp_out,
  output logic pump_up,
  output logic pump_dn,
  output logic pwr_down
);
  localparam int WORD_W = 1 + ((RDIV_W > NDIV_W + 3) ? RDIV_W : NDIV_W + 3);

  logic              sclk_q, le_q;
  logic [WORD_W-1:0] sr;
  logic [RDIV_W-1:0] r_div, r_cnt;
  logic [NDIV_W-1:0] n_div, n_cnt;
  logic              pd_bit, async_bit, pol_bit;
  logic              pd_q, fr_q, fp_q, up_q, dn_q;

  wire shift_ev = ser_clk & ~sclk_q;
  wire latch_ev = ser_le & ~le_q;
  wire r_wrap   = ({1'b0, r_cnt} + {{RDIV_W{1'b0}}, 1'b1}) >= {1'b0, r_div};
  wire n_wrap   = ({1'b0, n_cnt} + {{NDIV_W{1'b0}}, 1'b1}) >= {1'b0, n_div};
  wire set_up   = pol_bit ? fr_q : fp_q;
  wire set_dn   = pol_bit ? fp_q : fr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      sr     <= '0;
    end else begin
      sclk_q <= ser_clk;
      le_q   <= ser_le;
      if (shift_ev) sr <= {sr[WORD_W-2:0], ser_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_div     <= RDIV_W'(1);
      n_div     <= NDIV_W'(1);
      pd_bit    <= 1'b0;
      async_bit <= 1'b0;
      pol_bit   <= 1'b1;
    end else if (latch_ev) begin
      if (!sr[0]) begin
        r_div <= sr[RDIV_W:1];
      end else begin
        pd_bit    <= sr[1];
        async_bit <= sr[2];
        pol_bit   <= sr[3];
        n_div     <= sr[NDIV_W+3:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pd_q <= 1'b0;
    else if (!pd_bit)          pd_q <= 1'b0;
    else if (async_bit)        pd_q <= 1'b1;
    else if (!up_q && !dn_q)   pd_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt <= '0;
      fr_q  <= 1'b0;
    end else if (pd_q) begin
      r_cnt <= '0;
      fr_q  <= 1'b0;
    end else begin
      fr_q <= ref_tick & r_wrap;
      if (ref_tick) r_cnt <= r_wrap ? '0 : r_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt <= '0;
      fp_q  <= 1'b0;
    end else if (pd_q) begin
      n_cnt <= '0;
      fp_q  <= 1'b0;
    end else begin
      fp_q <= fb_tick & n_wrap;
      if (fb_tick) n_cnt <= n_wrap ? '0 : n_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (pd_q || (up_q && dn_q)) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | set_up;
      dn_q <= dn_q | set_dn;
    end
  end

  assign fr_out   = fr_q;
  assign fp_out   = fp_q;
  assign pump_up  = up_q & ~pd_q;
  assign pump_dn  = dn_q & ~pd_q;
  assign pwr_down = pd_q;
endmodule

// File: rtl/synth_pd_core_chk.sv
module synth_pd_core_chk #(
  parameter int RDIV_W = 8,
  parameter int NDIV_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_data,
  input logic              shift_ev,
  input logic              latch_ev,
  input logic [2:0]        sr_lo,
  input logic              pd_bit,
  input logic              async_bit,
  input logic              up_q,
  input logic              dn_q,
  input logic [RDIV_W-1:0] r_cnt,
  input logic [NDIV_W-1:0] n_cnt,
  input logic [NDIV_W-1:0] n_div,
  input logic              fr_out,
  input logic              fp_out,
  input logic              pump_up,
  input logic              pump_dn,
  input logic              pwr_down
);
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> sr_lo[0] == $past(ser_data));

  assert_select_keeps_n_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev && !sr_lo[0] |=> $stable(n_div));

  assert_min_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pump_up && pump_dn |=> !pump_up && !pump_dn);

  assert_async_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev && sr_lo[0] && sr_lo[1] && sr_lo[2] |=> ##1 pwr_down);

  assert_sync_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) && !$past(async_bit) |-> !$past(up_q) && !$past(dn_q));

  assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_bit |=> !pwr_down);

  assert_quiet_pump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !pump_up && !pump_dn);

  assert_frozen_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down && $past(pwr_down) |-> r_cnt == '0 && n_cnt == '0 && !fr_out && !fp_out);

  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> r_cnt == '0 && n_cnt == '0);
endmodule

bind synth_pd_core synth_pd_core_chk #(.RDIV_W(RDIV_W), .NDIV_W(NDIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .shift_ev(shift_ev),
  .latch_ev(latch_ev), .sr_lo(sr[2:0]), .pd_bit(pd_bit), .async_bit(async_bit),
  .up_q(up_q), .dn_q(dn_q), .r_cnt(r_cnt), .n_cnt(n_cnt), .n_div(n_div),
  .fr_out(fr_out), .fp_out(fp_out), .pump_up(pump_up), .pump_dn(pump_dn),
  .pwr_down(pwr_down)
);

// File: tb/synth_pd_core_tb.sv
module synth_pd_core_tb_top;
  localparam int RW = 8;
  localparam int NW = 10;
  localparam int W  = 1 + ((RW > NW + 3) ? RW : NW + 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic ref_tick = 1'b0, fb_tick = 1'b0;
  logic fr_out, fp_out, pump_up, pump_dn, pwr_down;

  int checks = 0, errors = 0;
  int fr_seen = 0, fp_seen = 0, up_seen = 0, dn_seen = 0, both_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  synth_pd_core #(.RDIV_W(RW), .NDIV_W(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .fr_out(fr_out), .fp_out(fp_out), .pump_up(pump_up), .pump_dn(pump_dn),
    .pwr_down(pwr_down)
  );

  // behavioural reference model
  bit sq[$];
  bit m_sclk, m_le, m_pd_bit, m_async, m_pol, m_pd, m_fr, m_fp, m_up, m_dn;
  int m_rdiv, m_ndiv, m_rc, m_nc;

  task automatic model_reset();
    sq.delete();
    for (int i = 0; i < W; i++) sq.push_back(1'b0);
    m_sclk = 0; m_le = 0; m_pd_bit = 0; m_async = 0; m_pol = 1;
    m_pd = 0; m_fr = 0; m_fp = 0; m_up = 0; m_dn = 0;
    m_rdiv = 1; m_ndiv = 1; m_rc = 0; m_nc = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit npd, nfr, nfp, nup, ndn, su, sd;
      int nrc, nnc;
      npd = m_pd;
      if (!m_pd_bit) npd = 0;
      else if (m_async) npd = 1;
      else if (!m_up && !m_dn) npd = 1;
      nrc = m_rc; nnc = m_nc; nfr = 0; nfp = 0;
      if (m_pd) begin nrc = 0; nnc = 0; end
      else begin
        if (ref_tick) begin
          if (m_rc + 1 >= m_rdiv) begin nrc = 0; nfr = 1; end else nrc = m_rc + 1;
        end
        if (fb_tick) begin
          if (m_nc + 1 >= m_ndiv) begin nnc = 0; nfp = 1; end else nnc = m_nc + 1;
        end
      end
      su = m_pol ? m_fr : m_fp;
      sd = m_pol ? m_fp : m_fr;
      if (m_pd || (m_up && m_dn)) begin nup = 0; ndn = 0; end
      else begin nup = m_up | su; ndn = m_dn | sd; end
      if (ser_le && !m_le) begin
        int word;
        word = 0;
        for (int i = 0; i < W; i++) if (sq[W-1-i]) word |= (1 << i);
        if ((word & 1) == 0) m_rdiv = (word >> 1) & ((1 << RW) - 1);
        else begin
          m_pd_bit = word[1]; m_async = word[2]; m_pol = word[3];
          m_ndiv = (word >> 4) & ((1 << NW) - 1);
        end
      end
      if (ser_clk && !m_sclk) begin
        sq.push_back(ser_data);
        void'(sq.pop_front());
      end
      m_sclk = ser_clk; m_le = ser_le;
      m_pd = npd; m_rc = nrc; m_nc = nnc; m_fr = nfr; m_fp = nfp;
      m_up = nup; m_dn = ndn;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", "fr_out model", fr_out, m_fr);
      chk("R3", "fp_out model", fp_out, m_fp);
      chk("R4/R5", "pump_up model", pump_up, m_up && !m_pd);
      chk("R4/R5", "pump_dn model", pump_dn, m_dn && !m_pd);
      chk("R6/R7/R8", "pwr_down model", pwr_down, m_pd);
      fr_seen += fr_out; fp_seen += fp_out;
      up_seen += pump_up; dn_seen += pump_dn;
      both_seen += (pump_up && pump_dn);
    end
  end

  task automatic clear_seen();
    fr_seen = 0; fp_seen = 0; up_seen = 0; dn_seen = 0; both_seen = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] bits, int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = bits[i]; ser_clk = 1'b0;
      wait_cyc(1); ser_clk = 1'b1;
      wait_cyc(2); ser_clk = 1'b0;
    end
    @(negedge clk); ser_le = 1'b1;
    wait_cyc(2); ser_le = 1'b0;
  endtask

  function automatic logic [31:0] r_word(int r);
    return 32'(r) << 1;
  endfunction

  function automatic logic [31:0] n_word(bit pd, bit imm, bit pol, int n);
    return 32'(1) | (32'(pd) << 1) | (32'(imm) << 2) | (32'(pol) << 3) | (32'(n) << 4);
  endfunction

  task automatic ticks(int n, bit use_ref, bit use_fb);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = use_ref; fb_tick = use_fb;
      @(negedge clk); ref_tick = 1'b0; fb_tick = 1'b0;
      wait_cyc(2);
    end
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    // R12 reset state
    chk("R12", "pwr_down after reset", pwr_down, 0);
    chk("R12", "pump_up after reset", pump_up, 0);
    chk("R12", "pump_dn after reset", pump_dn, 0);

    // R1: three junk leading bits are discarded; R2 reference word
    send_bits(32'h7 << W | r_word(4), W + 3);
    send_bits(n_word(0, 0, 1, 4), W);
    clear_seen();
    ticks(40, 1, 1);
    chk("R1/R3", "fr pulses, R=4 over 40 ticks", fr_seen, 10);
    chk("R3", "fp pulses, N=4 over 40 ticks", fp_seen, 10);
    chk("R5", "in-phase min-width pulse pairs", both_seen, 10);

    // R2: reference word leaves the feedback divider untouched
    send_bits(r_word(2), W);
    clear_seen();
    ticks(40, 1, 1);
    chk("R2", "fr pulses after R=2", fr_seen, 20);
    chk("R2", "fp pulses unchanged N=4", fp_seen, 10);

    // R4: inverted polarity
    send_bits(n_word(0, 0, 0, 1), W);
    send_bits(r_word(1), W);
    wait_cyc(4);
    ticks(1, 1, 0);
    chk("R4", "pump_dn with pol=0 after fr", pump_dn, 1);
    chk("R4", "pump_up with pol=0 after fr", pump_up, 0);
    ticks(1, 0, 1);
    chk("R5", "both cleared after fp", pump_up | pump_dn, 0);
    send_bits(n_word(0, 0, 1, 1), W);
    ticks(1, 1, 0);
    chk("R4", "pump_up with pol=1 after fr", pump_up, 1);
    chk("R4", "pump_dn with pol=1 after fr", pump_dn, 0);

    // R7: synchronous power-down waits for the pending up request
    send_bits(n_word(1, 0, 1, 1), W);
    wait_cyc(10);
    chk("R7", "pwr_down held off while up active", pwr_down, 0);
    ticks(1, 0, 1);
    wait_cyc(4);
    chk("R7", "pwr_down after pulse completes", pwr_down, 1);

    // R9: frozen while powered down
    clear_seen();
    ticks(20, 1, 1);
    chk("R9", "fr pulses while down", fr_seen, 0);
    chk("R9", "fp pulses while down", fp_seen, 0);
    chk("R9", "pump cycles while down", up_seen + dn_seen, 0);

    // R11: write reference value during power-down, then R10 power-up
    send_bits(r_word(3), W);
    chk("R11", "still down after R word", pwr_down, 1);
    send_bits(n_word(0, 0, 1, 5), W);
    wait_cyc(2);
    chk("R10", "pwr_down cleared", pwr_down, 0);
    clear_seen();
    ticks(2, 1, 1);
    chk("R10/R11", "no fr after 2 ticks", fr_seen, 0);
    ticks(1, 1, 1);
    chk("R10/R11", "first fr after 3rd tick", fr_seen, 1);
    ticks(1, 1, 1);
    chk("R10", "no fp after 4 ticks", fp_seen, 0);
    ticks(1, 1, 1);
    chk("R10", "first fp after 5th tick", fp_seen, 1);

    // R6: immediate power-down despite active up request
    ticks(1, 1, 0);
    chk("R6", "up pending before immediate word", pump_up, 1);
    send_bits(n_word(1, 1, 1, 5), W);
    wait_cyc(1);
    chk("R6", "immediate pwr_down", pwr_down, 1);

    // R8: cancel a pending synchronous request
    send_bits(n_word(0, 0, 1, 5), W);
    wait_cyc(2);
    ticks(3, 1, 0);
    chk("R8", "up pending before sync request", pump_up, 1);
    send_bits(n_word(1, 0, 1, 5), W);
    wait_cyc(5);
    chk("R8", "sync request still pending", pwr_down, 0);
    send_bits(n_word(0, 0, 1, 5), W);
    ticks(5, 0, 1);
    wait_cyc(10);
    chk("R8", "cancelled request never enters", pwr_down, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule